// File: doc/BRIEF.md
# Split-Read 64-bit Performance Counter Bank

This block keeps three free-running 64-bit counters for one hardware thread. The first counts core clock cycles. The second counts ticks of a constant-rate real-time strobe. The third counts retired instructions. All three are read-only. A core with a 32-bit data path reads each counter as two words at separate 12-bit register addresses. The bank answers any address placed on its read port within the same cycle: it returns the data and raises a hit flag.

The cycle counter stops while the core clock is gated off. The time counter keeps its own pace and ignores the core clock enable. The instruction counter adds up to two retirements in a single step.

Each counter steps across its full 64 bits in one update. The upper word therefore changes in the very cycle the lower word wraps. Software can read the upper word, then the lower word, then the upper word again, and retry when the two upper reads differ. Every accepted pair is then a value the counter really held. A width parameter switches the port to 64-bit reads, in which case only the lower-word addresses respond.

Top module: `perf_counter_bank`

## Requirements
- R1: A synchronous active-high reset loads all three counters with the parameter RESET_VAL (default zero).
- R2: The cycle counter adds 1 on every clock edge where coreClkEn is high and holds its value when coreClkEn is low.
- R3: The time counter adds 1 on every clock edge where timeTick is high, whatever the value of coreClkEn, and otherwise holds.
- R4: The instruction counter adds retireCnt (0, 1 or 2) on edges where coreClkEn is high. A retireCnt of 3 counts as 2. The instruction counter does not change while coreClkEn is low.
- R5: With READ_W = 32, address 0xC00 returns cycle bits 31:0, 0xC01 returns time bits 31:0 and 0xC02 returns instruction-count bits 31:0. Each read is combinational from the current counter state, with rdHit = 1.
- R6: With READ_W = 32, addresses 0xC80, 0xC81 and 0xC82 return bits 63:32 of cycle, time and instruction count, with rdHit = 1.
- R7: The upper word of a counter increments on the same edge where its lower word wraps. As a result, an upper-lower-upper read sequence with equal upper values yields the counter's true 64-bit value at the time of the lower read.
- R8: Any address not listed for the active read width gives rdHit = 0 and rdData = 0.
- R9: With READ_W = 64, addresses 0xC00, 0xC01 and 0xC02 return the full 64-bit counters, and 0xC80, 0xC81 and 0xC82 give rdHit = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| coreClkEn | input | 1 | High when the core clock is running (not gated) |
| timeTick | input | 1 | One-cycle strobe at the constant real-time rate |
| retireCnt | input | 2 | Instructions retired this cycle (0 to 2) |
| csrAddr | input | 12 | Register address being read |
| rdData | output | READ_W | Read data for csrAddr |
| rdHit | output | 1 | High when csrAddr selects a counter word |

## Verification
On every cycle, the assertions check the per-edge stepping of each counter and its hold under gating. They also check that the upper word moves exactly when the lower word wraps, that the upper-word addresses show the true top bits, and that misses read as zero. The behavioural reference model compares both read widths on every cycle across the address space. Only the bench's scenarios can show that a retried upper-lower-upper read returns a consistent value across a real wrap, and that the reset value is observable at the ports. A non-zero reset value close to a 32-bit wrap lets those wraps happen within a short run.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;
  localparam int CNT_W   = 64;
  localparam int ADDR_W  = 12;
  localparam int NUM_CTR = 3;
  localparam int STEP_W  = 2;
  localparam logic [ADDR_W-1:0] LO_BASE = 12'hC00;
  localparam logic [ADDR_W-1:0] HI_BASE = 12'hC80;

  typedef enum logic [1:0] {
    CTR_CYCLE   = 2'd0,
    CTR_TIME    = 2'd1,
    CTR_INSTRET = 2'd2
  } ctrSel_e;

  typedef struct packed {
    logic    hit;
    logic    upper;
    ctrSel_e sel;
  } rdStrobe_t;

  typedef struct packed {
    logic              cycInc;
    logic              timeInc;
    logic [STEP_W-1:0] retAdd;
  } incStrobe_t;
endpackage

// File: rtl/perf_ctr_ctrl.sv
module perf_ctr_ctrl
  import perf_ctr_pkg::*;
#(
  parameter int READ_W = 32
) (
  input  logic              coreClkEn,
  input  logic              timeTick,
  input  logic [STEP_W-1:0] retireCnt,
  input  logic [ADDR_W-1:0] csrAddr,
  output rdStrobe_t         rdStb,
  output incStrobe_t        incStb
);
  localparam bit SPLIT = (READ_W < CNT_W);
  localparam logic [STEP_W-1:0] MAX_RET = 2'd2;

  always_comb begin
    rdStb = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (csrAddr == LO_BASE + ADDR_W'(i)) begin
        rdStb.hit   = 1'b1;
        rdStb.upper = 1'b0;
        rdStb.sel   = ctrSel_e'(2'(i));
      end
      if (SPLIT && (csrAddr == HI_BASE + ADDR_W'(i))) begin
        rdStb.hit   = 1'b1;
        rdStb.upper = 1'b1;
        rdStb.sel   = ctrSel_e'(2'(i));
      end
    end
  end

  always_comb begin
    incStb.cycInc  = coreClkEn;
    incStb.timeInc = timeTick;
    if (!coreClkEn)
      incStb.retAdd = '0;
    else if (retireCnt > MAX_RET)
      incStb.retAdd = MAX_RET;
    else
      incStb.retAdd = retireCnt;
  end
endmodule

// File: rtl/perf_ctr_dp.sv
module perf_ctr_dp
  import perf_ctr_pkg::*;
#(
  parameter int               READ_W    = 32,
  parameter logic [CNT_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  incStrobe_t        incStb,
  input  rdStrobe_t         rdStb,
  output logic [READ_W-1:0] rdData,
  output logic [CNT_W-1:0]  cycleCnt,
  output logic [CNT_W-1:0]  timeCnt,
  output logic [CNT_W-1:0]  instretCnt
);
  logic [CNT_W-1:0]  ctrArr  [NUM_CTR];
  logic [STEP_W-1:0] stepAmt [NUM_CTR];
  logic [CNT_W-1:0]  selVal;

  assign stepAmt[CTR_CYCLE]   = {1'b0, incStb.cycInc};
  assign stepAmt[CTR_TIME]    = {1'b0, incStb.timeInc};
  assign stepAmt[CTR_INSTRET] = incStb.retAdd;

  // One full-width add per counter: upper word moves on the wrap edge.
  for (genvar g = 0; g < NUM_CTR; g++) begin : gCtr
    always_ff @(posedge clk) begin
      if (rst) ctrArr[g] <= RESET_VAL;
      else     ctrArr[g] <= ctrArr[g] + CNT_W'(stepAmt[g]);
    end
  end

  assign cycleCnt   = ctrArr[CTR_CYCLE];
  assign timeCnt    = ctrArr[CTR_TIME];
  assign instretCnt = ctrArr[CTR_INSTRET];

  always_comb begin
    case (rdStb.sel)
      CTR_CYCLE:   selVal = ctrArr[CTR_CYCLE];
      CTR_TIME:    selVal = ctrArr[CTR_TIME];
      CTR_INSTRET: selVal = ctrArr[CTR_INSTRET];
      default:     selVal = '0;
    endcase
  end

  always_comb begin
    if (!rdStb.hit)       rdData = '0;
    else if (rdStb.upper) rdData = READ_W'(selVal >> READ_W);
    else                  rdData = READ_W'(selVal);
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_ctr_pkg::*;
#(
  parameter int               READ_W    = 32,
  parameter logic [CNT_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              coreClkEn,
  input  logic              timeTick,
  input  logic [1:0]        retireCnt,
  input  logic [11:0]       csrAddr,
  output logic [READ_W-1:0] rdData,
  output logic              rdHit
);
  rdStrobe_t        rdStb;
  incStrobe_t       incStb;
  logic [CNT_W-1:0] cycleCnt;
  logic [CNT_W-1:0] timeCnt;
  logic [CNT_W-1:0] instretCnt;

  perf_ctr_ctrl #(.READ_W(READ_W)) ctrl_i (
    .coreClkEn (coreClkEn),
    .timeTick  (timeTick),
    .retireCnt (retireCnt),
    .csrAddr   (csrAddr),
    .rdStb     (rdStb),
    .incStb    (incStb)
  );

  perf_ctr_dp #(.READ_W(READ_W), .RESET_VAL(RESET_VAL)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .incStb     (incStb),
    .rdStb      (rdStb),
    .rdData     (rdData),
    .cycleCnt   (cycleCnt),
    .timeCnt    (timeCnt),
    .instretCnt (instretCnt)
  );

  assign rdHit = rdStb.hit;
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int READ_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              coreClkEn,
  input logic              timeTick,
  input logic [1:0]        retireCnt,
  input logic [11:0]       csrAddr,
  input logic [READ_W-1:0] rdData,
  input logic              rdHit,
  input logic [63:0]       cycleCnt,
  input logic [63:0]       timeCnt,
  input logic [63:0]       instretCnt
);
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (rst)
    coreClkEn |=> cycleCnt == $past(cycleCnt) + 64'd1); // R2
  AST_CYCLE_GATED: assert property (@(posedge clk) disable iff (rst)
    !coreClkEn |=> $stable(cycleCnt)); // R2
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
    timeTick |=> timeCnt == $past(timeCnt) + 64'd1); // R3
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (rst)
    !timeTick |=> $stable(timeCnt)); // R3
  AST_RETIRE_ADD: assert property (@(posedge clk) disable iff (rst)
    coreClkEn |=> instretCnt == $past(instretCnt) +
      (($past(retireCnt) == 2'd3) ? 64'd2 : 64'($past(retireCnt)))); // R4
  AST_RETIRE_GATED: assert property (@(posedge clk) disable iff (rst)
    !coreClkEn |=> $stable(instretCnt)); // R4
  AST_CARRY_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(cycleCnt[31:0]) > cycleCnt[31:0])) |->
      cycleCnt[63:32] == $past(cycleCnt[63:32]) + 32'd1); // R7
  AST_UPPER_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(cycleCnt[31:0]) <= cycleCnt[31:0])) |->
      $stable(cycleCnt[63:32])); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rdHit |-> rdData == '0); // R8

  if (READ_W == 32) begin : gSplit
    AST_UPPER_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (csrAddr == 12'hC80) |-> rdHit && rdData == cycleCnt[63:32]); // R6
    AST_LOWER_TIME: assert property (@(posedge clk) disable iff (rst)
      (csrAddr == 12'hC01) |-> rdHit && rdData == timeCnt[31:0]); // R5
  end else begin : gWide
    AST_WIDE_NO_UPPER: assert property (@(posedge clk) disable iff (rst)
      (csrAddr == 12'hC80 || csrAddr == 12'hC81 || csrAddr == 12'hC82) |-> !rdHit); // R9
  end
endmodule

bind perf_counter_bank perf_counter_bank_chk #(.READ_W(READ_W)) chk_i (.*);

// File: tb/perf_counter_bank_tb_top.sv
module perf_counter_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] START = 64'h0000_0001_FFFF_FF80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coreClkEn = 1'b0;
  logic        timeTick = 1'b0;
  logic [1:0]  retireCnt = 2'd0;
  logic [11:0] csrAddr = 12'h000;
  logic [31:0] rdData;
  logic        rdHit;
  logic [63:0] rdData64;
  logic        rdHit64;

  always #(CLK_PERIOD/2) clk = ~clk;

  perf_counter_bank #(.READ_W(32), .RESET_VAL(START)) dut_i (
    .clk(clk), .rst(rst), .coreClkEn(coreClkEn), .timeTick(timeTick),
    .retireCnt(retireCnt), .csrAddr(csrAddr), .rdData(rdData), .rdHit(rdHit));

  perf_counter_bank #(.READ_W(64), .RESET_VAL(START)) dut64_i (
    .clk(clk), .rst(rst), .coreClkEn(coreClkEn), .timeTick(timeTick),
    .retireCnt(retireCnt), .csrAddr(csrAddr), .rdData(rdData64), .rdHit(rdHit64));

  longint unsigned mCyc, mTime, mRet;
  int    checks = 0;
  int    errors = 0;
  string tagOverride = "";
  logic [31:0] lastRd;
  logic [63:0] lastFull;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void expRead(input logic [11:0] a, input bit wide,
                                  output bit hit, output logic [63:0] data,
                                  output string tag);
    int idx = -1;
    bit up = 0;
    longint unsigned v;
    if (a >= 12'hC00 && a <= 12'hC02) idx = int'(a - 12'hC00);
    else if (!wide && a >= 12'hC80 && a <= 12'hC82) begin
      idx = int'(a - 12'hC80); up = 1;
    end
    if (idx < 0) begin
      hit = 0; data = '0;
      tag = (wide && a >= 12'hC80 && a <= 12'hC82) ? "R9" : "R8";
      return;
    end
    v = (idx == 0) ? mCyc : (idx == 1) ? mTime : mRet;
    hit = 1;
    data = wide ? v : (up ? {32'h0, v[63:32]} : {32'h0, v[31:0]});
    tag = (idx == 0) ? "R2" : (idx == 1) ? "R3" : "R4";
    tag = {tag, wide ? " R9" : (up ? " R6" : " R5")};
  endfunction

  task automatic step(input bit en, input bit tick, input logic [1:0] ret,
                      input logic [11:0] a);
    bit hitE;
    logic [63:0] dataE;
    string tg;
    @(negedge clk);
    coreClkEn = en; timeTick = tick; retireCnt = ret; csrAddr = a;
    #1;
    expRead(a, 1'b0, hitE, dataE, tg);
    if (tagOverride != "") tg = tagOverride;
    check(rdHit == hitE && {32'h0, rdData} == dataE, tg,
          {31'h0, rdHit, rdData}, {31'h0, hitE, dataE[31:0]});
    lastRd = rdData;
    lastFull = mCyc;
    expRead(a, 1'b1, hitE, dataE, tg);
    if (tagOverride != "") tg = tagOverride;
    check(rdHit64 == hitE && rdData64 == dataE, tg, rdData64, dataE);
    @(posedge clk);
    if (en) begin
      mCyc++;
      mRet += (ret == 2'd3) ? 2 : longint'(ret);
    end
    if (tick) mTime++;
  endtask

  function automatic logic [11:0] pickAddr();
    case ($urandom_range(0, 8))
      0: return 12'hC00;
      1: return 12'hC01;
      2: return 12'hC02;
      3: return 12'hC80;
      4: return 12'hC81;
      5: return 12'hC82;
      6: return 12'hC03;
      7: return 12'hC83;
      default: return 12'($urandom);
    endcase
  endfunction

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    logic [31:0] h1, h2, lo;
    logic [63:0] full;
    int retries = 0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    mCyc = START; mTime = START; mRet = START;
    @(negedge clk);
    rst = 1'b0;

    // R1: reset value visible at every address while idle
    tagOverride = "R1";
    step(0, 0, 0, 12'hC00); step(0, 0, 0, 12'hC80);
    step(0, 0, 0, 12'hC01); step(0, 0, 0, 12'hC81);
    step(0, 0, 0, 12'hC02); step(0, 0, 0, 12'hC82);
    tagOverride = "";

    // R7: upper-lower-upper retry reads across the cycle-counter wrap
    for (int n = 0; n < 80; n++) begin
      step(1, 0, 0, 12'hC80); h1 = lastRd;
      step(1, 0, 0, 12'hC00); lo = lastRd; full = lastFull;
      step(1, 0, 0, 12'hC80); h2 = lastRd;
      if (h1 == h2) check({h1, lo} == full, "R7 retry read", {h1, lo}, full);
      else retries++;
    end
    check(retries > 0 && mCyc[63:32] == 32'h2, "R7 wrap seen",
          64'(retries), 64'd1);

    // R2 R3 R4 R5 R6 R8: clock running, random tick and retire
    for (int n = 0; n < 400; n++)
      step(1, 1'($urandom), 2'($urandom), pickAddr());

    // R2 R4: gating toggled, time keeps its own pace (R3)
    for (int n = 0; n < 600; n++)
      step(($urandom_range(0, 3) == 0), 1'($urandom), 2'($urandom), pickAddr());

    // R3: long gated stretch, only time ticks
    for (int n = 0; n < 300; n++)
      step(0, 1, 2'd3, pickAddr());

    // R4: retire count 3 saturates to 2
    for (int n = 0; n < 200; n++)
      step(1, 0, 2'd3, (n % 2 == 0) ? 12'hC02 : 12'hC82);

    finishRun();
  end
endmodule